// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block services one cache miss at a time by fetching the missing line from the next memory level as a wrapped burst. The burst starts at the beat that holds the requested word. That beat goes to the processor return port as soon as it arrives, so the processor can restart while the rest of the line is still in flight. Every beat, the first one included, is also written into the cache line buffer at its own position in the line.

A line is 64 bytes, moved as eight beats of 8 bytes. The block issues one memory request per miss. The request carries the miss address aligned to its beat, which tells memory where to begin the wrap. The responses are then counted in arrival order. Arrival k (k = 0..7) belongs at beat position (critical + k) mod 8. Once all eight positions are written, a completion pulse marks the line valid. While a fill is in progress the block refuses new misses. Tag lookup, victim choice and memory timing live outside the block. With a memory that answers after 11 cycles and then every 2 cycles, the whole line is in after 11 + 2 × 7 = 25 cycles.

Top module: `wrapfill_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, miss_ready is 1 and mreq_valid, cpu_valid, lw_valid and line_done are all 0.
- R2: A miss is accepted on a clock edge where miss_valid and miss_ready are both 1. In the next cycle mreq_valid is 1 for exactly one cycle, and mreq_addr equals the miss address with bits [2:0] cleared.
- R3: miss_ready is 0 from the cycle after acceptance through the cycle that shows the eighth line write. A miss presented during that time is not taken, and it is accepted only once miss_ready returns.
- R4: The critical beat is miss address bits [5:3] and the line set is bits [11:6]. The k-th response (k from 0) sampled while the fill collects beats appears one cycle later as lw_valid = 1, with lw_beat = (critical + k) mod 8, lw_set = the set and lw_data = the response data.
- R5: The first response of a fill appears on cpu_valid/cpu_data in the same cycle as its line write. cpu_valid is 1 exactly once per fill.
- R6: line_done is 1 for one cycle, with line_set equal to the fill's set, in the cycle after the eighth line write. It never shows in the same cycle as a write. miss_ready is 1 in that cycle.
- R7: A response with mrsp_valid = 1 while no fill is collecting beats (idle, request cycle, after the eighth beat) causes no line write and no processor return.
- R8: At line_done, the eight written beats equal the memory contents of the line at positions 0..7, and each position was written exactly once.
- R9: When memory answers 11 cycles after the edge that ends the request cycle and then every 2 cycles, cpu_valid shows 11 cycles after that edge and line_done shows 26 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | ADDR_W | Byte address of the missed word |
| miss_ready | output | 1 | Block can accept a miss (idle) |
| mreq_valid | output | 1 | One-cycle memory burst request |
| mreq_addr | output | ADDR_W | Beat-aligned start address of the wrapped burst |
| mrsp_valid | input | 1 | Memory beat present |
| mrsp_data | input | 8*BEAT_BYTES | Memory beat data |
| cpu_valid | output | 1 | Requested word forwarded to processor |
| cpu_data | output | 8*BEAT_BYTES | Forwarded beat |
| lw_valid | output | 1 | Line buffer beat write |
| lw_set | output | INDEX_W | Set of the line being filled |
| lw_beat | output | log2(LINE_BEATS) | Beat position within the line |
| lw_data | output | 8*BEAT_BYTES | Beat write data |
| line_done | output | 1 | Line complete, set its valid bit |
| line_set | output | INDEX_W | Set whose line completed |

## Verification
Two functions can coincide in one cycle. The completion pulse of one fill can come in the same cycle in which the next miss is accepted. The bench provokes this by holding miss_valid high across whole fills with the next address already waiting. The reference model must then show line_done for the old set, and the next edge must take the new address with the request following one cycle later. The critical word's forward and its line write also share a cycle. Every cycle, both ports are compared against a behavioural model, and the line gathered from the write port is checked against the bench memory when the line completes.

// File: rtl/wfc_pkg.sv
// Shared types for the wrapped line fill controller.
package wfc_pkg;
    // Fill progress: idle, request issue, beat collection, final write shown.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BEATS = 2'd2,
        ST_LAST  = 2'd3
    } fill_st_e;
endpackage

// File: rtl/wfc_addr_split.sv
// Splits a miss address into the critical beat, the line set and the
// beat-aligned burst start address. Pure combinational.
// Assumes: address layout is {tag, set, beat, byte-in-beat}.
module wfc_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 3,
    parameter int BSEL_W  = 3,
    parameter int INDEX_W = 6
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [BSEL_W-1:0]  crit,
    output logic [INDEX_W-1:0] set_idx,
    output logic [ADDR_W-1:0]  start_addr
);
    localparam logic [ADDR_W-1:0] BYTE_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    // Field extraction and beat alignment.
    always_comb begin
        crit       = addr[OFF_W +: BSEL_W];
        set_idx    = addr[OFF_W+BSEL_W +: INDEX_W];
        start_addr = addr & ~BYTE_MASK;
    end
endmodule

// File: rtl/wfc_sequencer.sv
// Fill state machine and beat counter. Captures the miss fields on
// acceptance, counts responses while collecting, and yields the wrapped
// beat position of each response.
// Assumes: beats per line is a power of two, so the position wraps by
// plain truncation of crit + count.
module wfc_sequencer
    import wfc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BSEL_W  = 3,
    parameter int INDEX_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [BSEL_W-1:0]  crit_in,
    input  logic [INDEX_W-1:0] set_in,
    input  logic [ADDR_W-1:0]  start_in,
    input  logic               rsp_valid,
    output fill_st_e           state,
    output logic [BSEL_W-1:0]  beat_pos,
    output logic [INDEX_W-1:0] set_q,
    output logic [ADDR_W-1:0]  start_q,
    output logic               take,
    output logic               first_beat
);
    localparam logic [BSEL_W-1:0] LAST_K = {BSEL_W{1'b1}};

    logic [BSEL_W-1:0] crit_q;
    logic [BSEL_W-1:0] cnt_q;

    // A response counts only while beats are being collected.
    always_comb begin
        take       = (state == ST_BEATS) && rsp_valid;
        first_beat = (cnt_q == '0);
        beat_pos   = crit_q + cnt_q;
    end

    // State transitions of one fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept) state <= ST_REQ;
                ST_REQ:   state <= ST_BEATS;
                ST_BEATS: if (take && cnt_q == LAST_K) state <= ST_LAST;
                ST_LAST:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Capture of the miss fields and the arrival counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q  <= '0;
            set_q   <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            crit_q  <= crit_in;
            set_q   <= set_in;
            start_q <= start_in;
            cnt_q   <= '0;
        end else if (take) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wfc_beat_out.sv
// Registered output stage: line buffer write, processor forward of the
// first arriving beat, and the completion pulse one cycle after the
// final write is shown.
// Assumes: take and closing are never high together.
module wfc_beat_out #(
    parameter int BEAT_W  = 64,
    parameter int BSEL_W  = 3,
    parameter int INDEX_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               first_beat,
    input  logic               closing,
    input  logic [BSEL_W-1:0]  beat_pos,
    input  logic [INDEX_W-1:0] set_q,
    input  logic [BEAT_W-1:0]  rsp_data,
    output logic               cpu_valid,
    output logic [BEAT_W-1:0]  cpu_data,
    output logic               lw_valid,
    output logic [INDEX_W-1:0] lw_set,
    output logic [BSEL_W-1:0]  lw_beat,
    output logic [BEAT_W-1:0]  lw_data,
    output logic               line_done,
    output logic [INDEX_W-1:0] line_set
);
    // Line buffer write port, one beat per accepted response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_valid <= 1'b0;
            lw_set   <= '0;
            lw_beat  <= '0;
            lw_data  <= '0;
        end else begin
            lw_valid <= take;
            if (take) begin
                lw_set  <= set_q;
                lw_beat <= beat_pos;
                lw_data <= rsp_data;
            end
        end
    end

    // Early restart: forward only the first arrival of the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_valid <= 1'b0;
            cpu_data  <= '0;
        end else begin
            cpu_valid <= take && first_beat;
            if (take && first_beat) cpu_data <= rsp_data;
        end
    end

    // Completion pulse after the last write has been presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_done <= 1'b0;
            line_set  <= '0;
        end else begin
            line_done <= closing;
            if (closing) line_set <= set_q;
        end
    end
endmodule

// File: rtl/wrapfill_ctrl.sv
// Top of the critical-word-first line fill controller. One miss at a
// time: issues a beat-aligned wrapped burst request, forwards the first
// returned beat to the processor, writes every beat into the line buffer
// at its wrapped position and pulses completion at the end.
// Assumes: memory returns exactly LINE_BEATS beats per request, starting
// at the requested beat and wrapping; LINE_BEATS and BEAT_BYTES are
// powers of two.
module wrapfill_ctrl
    import wfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BEATS = 8,
    parameter int INDEX_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_valid,
    input  logic [ADDR_W-1:0]             miss_addr,
    output logic                          miss_ready,
    output logic                          mreq_valid,
    output logic [ADDR_W-1:0]             mreq_addr,
    input  logic                          mrsp_valid,
    input  logic [8*BEAT_BYTES-1:0]       mrsp_data,
    output logic                          cpu_valid,
    output logic [8*BEAT_BYTES-1:0]       cpu_data,
    output logic                          lw_valid,
    output logic [INDEX_W-1:0]            lw_set,
    output logic [$clog2(LINE_BEATS)-1:0] lw_beat,
    output logic [8*BEAT_BYTES-1:0]       lw_data,
    output logic                          line_done,
    output logic [INDEX_W-1:0]            line_set
);
    localparam int BEAT_W = 8 * BEAT_BYTES;
    localparam int OFF_W  = $clog2(BEAT_BYTES);
    localparam int BSEL_W = $clog2(LINE_BEATS);

    fill_st_e           st;
    logic               accept;
    logic [BSEL_W-1:0]  crit_w;
    logic [INDEX_W-1:0] set_w;
    logic [ADDR_W-1:0]  start_w;
    logic [BSEL_W-1:0]  pos_w;
    logic [INDEX_W-1:0] set_q;
    logic               take_w;
    logic               first_w;

    // Handshake and request outputs derived from the fill state.
    always_comb begin
        miss_ready = (st == ST_IDLE);
        accept     = miss_valid && miss_ready;
        mreq_valid = (st == ST_REQ);
    end

    wfc_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .BSEL_W (BSEL_W),
        .INDEX_W(INDEX_W)
    ) u_split (
        .addr      (miss_addr),
        .crit      (crit_w),
        .set_idx   (set_w),
        .start_addr(start_w)
    );

    wfc_sequencer #(
        .ADDR_W (ADDR_W),
        .BSEL_W (BSEL_W),
        .INDEX_W(INDEX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .crit_in   (crit_w),
        .set_in    (set_w),
        .start_in  (start_w),
        .rsp_valid (mrsp_valid),
        .state     (st),
        .beat_pos  (pos_w),
        .set_q     (set_q),
        .start_q   (mreq_addr),
        .take      (take_w),
        .first_beat(first_w)
    );

    wfc_beat_out #(
        .BEAT_W (BEAT_W),
        .BSEL_W (BSEL_W),
        .INDEX_W(INDEX_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take_w),
        .first_beat(first_w),
        .closing   (st == ST_LAST),
        .beat_pos  (pos_w),
        .set_q     (set_q),
        .rsp_data  (mrsp_data),
        .cpu_valid (cpu_valid),
        .cpu_data  (cpu_data),
        .lw_valid  (lw_valid),
        .lw_set    (lw_set),
        .lw_beat   (lw_beat),
        .lw_data   (lw_data),
        .line_done (line_done),
        .line_set  (line_set)
    );
endmodule

// File: rtl/wfc_checks.sv
// Protocol checker for wrapfill_ctrl, attached by bind below.
// Assumes: the synchronous active-low reset is held low from time zero.
module wfc_checks (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic miss_ready,
    input logic mreq_valid,
    input logic cpu_valid,
    input logic lw_valid,
    input logic line_done
);
    // R1: reset leaves the block idle with all strobes low.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (miss_ready && !mreq_valid && !cpu_valid && !lw_valid && !line_done));

    // R2: an accepted miss yields a request in the next cycle.
    a_r2_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> mreq_valid);

    // R2: the request lasts a single cycle.
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |=> !mreq_valid);

    // R3: no miss is taken while the request is out.
    a_r3_busy_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> !miss_ready);

    // R3: no miss is taken while beats are written.
    a_r3_busy_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        lw_valid |-> !miss_ready);

    // R5: the forwarded word is written in the same cycle.
    a_r5_fwd_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> lw_valid);

    // R6: completion follows a write and never shares its cycle.
    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (!lw_valid && $past(lw_valid)));

    // R6: the block is ready again when completion shows.
    a_r6_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> miss_ready);
endmodule

bind wrapfill_ctrl wfc_checks u_wfc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_valid(miss_valid),
    .miss_ready(miss_ready),
    .mreq_valid(mreq_valid),
    .cpu_valid (cpu_valid),
    .lw_valid  (lw_valid),
    .line_done (line_done)
);

// File: tb/test_wrapfill_ctrl.sv
// Bench: behavioural reference model stepped every clock, a wrapped
// burst memory with 11/2 cycle timing, stray responses, and stream mode.
module test_wrapfill_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        mrsp_valid = 1'b0;
    logic [63:0] mrsp_data = '0;
    logic        miss_ready, mreq_valid, cpu_valid, lw_valid, line_done;
    logic [31:0] mreq_addr;
    logic [63:0] cpu_data, lw_data;
    logic [5:0]  lw_set, line_set;
    logic [2:0]  lw_beat;

    wrapfill_ctrl i_wrapfill_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
        .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .cpu_valid(cpu_valid),
        .cpu_data(cpu_data), .lw_valid(lw_valid), .lw_set(lw_set), .lw_beat(lw_beat),
        .lw_data(lw_data), .line_done(line_done), .line_set(line_set)
    );

    always #2 clk = ~clk;

    int vecs = 0, errs = 0, cyc = 0;
    // reference model state
    int m_st = 0, m_k = 0, m_crit = 0;
    logic [5:0]  m_set = '0;
    logic [31:0] m_base = '0, m_start = '0;
    bit          e_cpu = 0, e_lw = 0, e_done = 0;
    logic [63:0] e_cpu_d = '0, e_lw_d = '0;
    logic [2:0]  e_beat = '0;
    logic [5:0]  e_set = '0, e_dset = '0;
    // bench memory and line gather
    bit          mem_on = 0, stray_en = 0, stray_now = 0;
    int          mem_p = 0;
    logic [31:0] mem_start = '0;
    logic [63:0] lbuf [8];
    int          lcnt [8];

    function automatic logic [63:0] mw(logic [31:0] base, int b);
        return {base ^ 32'hC3D2_E1F0, (base + 32'(b) * 32'h0101_0101) ^ 32'h9E37_79B9};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    // Reference model: advance one clock with the inputs held at this edge.
    always @(posedge clk) begin
        cyc++;
        e_cpu = 0; e_lw = 0; e_done = 0;
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (miss_valid) begin
                    m_crit  = int'(miss_addr[5:3]);
                    m_set   = miss_addr[11:6];
                    m_base  = miss_addr & 32'hFFFF_FFC0;
                    m_start = miss_addr & 32'hFFFF_FFF8;
                    m_k     = 0;
                    m_st    = 1;
                end
                1: m_st = 2;
                2: if (mrsp_valid) begin
                    e_lw   = 1;
                    e_beat = 3'((m_crit + m_k) % 8);
                    e_set  = m_set;
                    e_lw_d = mrsp_data;
                    if (m_k == 0) begin
                        e_cpu   = 1;
                        e_cpu_d = mrsp_data;
                    end
                    m_k++;
                    if (m_k == 8) m_st = 3;
                end
                default: begin
                    e_done = 1;
                    e_dset = m_set;
                    m_st   = 0;
                end
            endcase
        end
    end

    // Compare every output mid-cycle, then drive the memory side.
    always @(negedge clk) begin
        if (cyc >= 1) begin
            chk(rst_n ? "R3" : "R1", "miss_ready", 64'(miss_ready), 64'(m_st == 0));
            chk(rst_n ? "R2" : "R1", "mreq_valid", 64'(mreq_valid), 64'(m_st == 1));
            if (rst_n && m_st == 1) chk("R2", "mreq_addr", 64'(mreq_addr), 64'(m_start));
            chk(stray_now ? "R7" : "R5", "cpu_valid", 64'(cpu_valid), 64'(e_cpu));
            chk(stray_now ? "R7" : "R4", "lw_valid", 64'(lw_valid), 64'(e_lw));
            chk(rst_n ? "R6" : "R1", "line_done", 64'(line_done), 64'(e_done));
            if (e_cpu && cpu_valid) begin
                chk("R5", "cpu_data", cpu_data, e_cpu_d);
                chk("R9", "forward delay", 64'(cyc - mem_p), 64'd11);
            end
            if (e_lw && lw_valid) begin
                chk("R4", "lw_beat", 64'(lw_beat), 64'(e_beat));
                chk("R4", "lw_set", 64'(lw_set), 64'(e_set));
                chk("R4", "lw_data", lw_data, e_lw_d);
                lbuf[lw_beat] = lw_data;
                lcnt[lw_beat]++;
            end
            if (e_done && line_done) begin
                chk("R6", "line_set", 64'(line_set), 64'(e_dset));
                chk("R9", "fill delay", 64'(cyc - mem_p), 64'd26);
                for (int i = 0; i < 8; i++) begin
                    chk("R8", "beat write count", 64'(lcnt[i]), 64'd1);
                    chk("R8", "line content", lbuf[i], mw(m_base, i));
                    lcnt[i] = 0;
                end
            end
        end
        // memory: first beat 11 edges after the request edge, then every 2
        stray_now = 0;
        mrsp_valid = 1'b0;
        if (mem_on) begin
            int d;
            d = cyc + 1 - mem_p - 11;
            if (d >= 0 && d % 2 == 0 && d / 2 < 8) begin
                mrsp_valid = 1'b1;
                mrsp_data  = mw(mem_start & 32'hFFFF_FFC0,
                                (int'(mem_start[5:3]) + d / 2) % 8);
            end else if (d > 14) begin
                mem_on = 0;
            end
        end else if (stray_en && ($urandom % 2 == 0)) begin
            mrsp_valid = 1'b1;
            mrsp_data  = {$urandom, $urandom};
            stray_now  = 1;
        end
        if (rst_n && mreq_valid) begin
            mem_on    = 1;
            mem_p     = cyc + 1;
            mem_start = mreq_addr;
        end
    end

    task automatic fill(logic [31:0] a);
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        miss_addr  = 32'hDEAD_BEEF;
        while (!miss_ready) @(negedge clk);
    endtask

    // Keep a miss always pending (R3 held request, R6 same-cycle accept).
    task automatic stream(int n);
        for (int i = 0; i < n; i++) begin
            bit r;
            @(negedge clk);
            miss_valid = 1'b1;
            miss_addr  = $urandom;
            forever begin
                r = miss_ready;
                @(negedge clk);
                if (r) break;
            end
        end
        miss_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) lcnt[i] = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fill(32'h0000_1040);          // critical beat 0, set 1
        fill(32'h0001_23F8);          // critical beat 7 (wrap at once)
        stray_en = 1;                 // R7: junk responses outside the fill
        for (int i = 0; i < 6; i++) fill($urandom);
        stream(30);
        stray_en = 0;
        stream(4);
        repeat (40) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end
endmodule